// File: doc/BRIEF.md
# Word-Framed Receive Buffer

This block is a circular buffer for received frames. Each frame is held as a run of 32-bit words whose length the frame describes itself. The producer streams a frame in one word per cycle with valid, first and last strobes. The first word is a header, and a 5-bit word-count field in that header gives the frame's total length. The space check happens when the header arrives. A frame that fits is written straight into storage but only becomes visible to the reader after its last word. A frame that does not fit is dropped whole and flagged as an overrun.

The consumer drains the buffer by pulsing `rd_en`, which acts as a read of a single data register. Each pulse pops the word shown on `rd_data`. A small tracker follows frame boundaries by loading the header's count whenever no frame is partly read, and it counts down the words that remain. The empty flag follows the number of stored frames, not the raw word count. Status outputs give the free space, the total size, both pointers, the frame count, the overrun flag and two event strobes. A release command flushes everything, and a separate command clears the overrun flag.

The write side is a three-state machine:
- `WR_IDLE` waits for a header. A header that fits moves to `WR_FILL`, or commits at once if it is also the last word.
- A header that does not fit moves to `WR_DROP`, or stays in `WR_IDLE` if it is also the last word.
- `WR_FILL` returns to `WR_IDLE` on the last word and commits the frame.
- `WR_DROP` returns to `WR_IDLE` on the last word.
- A release seen while a frame is in flight sends the machine to `WR_DROP` so that the rest of that frame is discarded.

Top module: `rx_word_fifo`

## Requirements
- R1: After reset the buffer is empty: `empty`=1, `full`=0, `free_words`=256, `size_words`=256, both pointers 0, `frame_count` 0, `overrun` 0, `frames_received` 0.
- R2: The header's word-count field sits in bits [15:11] and holds the frame length minus one. When the fill plus that length is at most 256, the frame is accepted. `ev_frame_in` pulses during the cycle of its last word. After that edge `free_words` has dropped by the length, and `frame_count` and `frames_received` have each risen by 1.
- R3: When the fill plus the header's length exceeds 256, the whole frame is discarded. `ev_overrun` pulses during the header cycle, and `overrun` is 1 after that edge. The stored contents, `wr_ptr`, `free_words` and `frame_count` are unchanged.
- R4: While words are stored, `rd_data` shows the word at `rd_ptr`. A cycle with `rd_en` advances `rd_ptr` by one modulo 256 and raises `free_words` by one. Words come out in the order they were accepted.
- R5: When no frame is partly read, the popped word is taken as a header, and its count plus one is the number of words left in that frame. `frame_count` drops by one only after the last word of a frame has been popped, so `empty` stays 0 while a frame is partly read.
- R6: With no words stored, `rd_data` is 0 and `rd_en` changes neither pointer nor any count.
- R7: `full` is 1 exactly when `free_words` is 0.
- R8: `wr_ptr` equals (`rd_ptr` + stored words) modulo 256.
- R9: `release_buf` zeroes the read pointer, the fill, the partial-frame count and `frame_count`. A frame being written at that moment is discarded up to its last word.
- R10: `clear_overrun` clears `overrun`. A new overrun in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Write word valid |
| wr_first | input | 1 | Word is a frame header |
| wr_last | input | 1 | Word is the frame's last |
| wr_data | input | 32 | Write word |
| rd_en | input | 1 | Pop one word (data-register read) |
| rd_data | output | 32 | Word at read pointer, 0 when no words stored |
| release_buf | input | 1 | Flush buffer command |
| clear_overrun | input | 1 | Clear overrun flag command |
| empty | output | 1 | No complete frame stored |
| full | output | 1 | No free word left |
| free_words | output | 9 | Free space in words |
| size_words | output | 9 | Total capacity in words |
| rd_ptr | output | 8 | Read pointer (word index) |
| wr_ptr | output | 8 | Committed write pointer (word index) |
| frame_count | output | 9 | Frames stored, including one partly read |
| overrun | output | 1 | Sticky overrun flag |
| ev_frame_in | output | 1 | Frame accepted this cycle |
| ev_overrun | output | 1 | Frame dropped for lack of space this cycle |
| frames_received | output | 32 | Accepted frame counter |

## Verification
The main function is driven with random frames of 4 to 21 words, interleaved with random bursts of 1 to 12 pops. This keeps the fill level close to capacity, so that accepts, overruns and pointer wrap all occur. Every popped word is compared with a queue model, which tells apart mistakes in data order and pointer wrap from mistakes in the fit check. Directed cases fill exactly 256 words with maximum-length frames, which separates an off-by-one in the fit check from the full flag. Further directed cases pop part of a frame to separate word-based from frame-based emptiness, release while a frame is in flight to show that its tail is discarded, and read while empty.

// File: rtl/rxwf_pkg.sv
package rxwf_pkg;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned CNT_LSB = 11;
    localparam int unsigned CNT_W   = 5;

    typedef enum logic [1:0] {
        WR_IDLE = 2'd0,
        WR_FILL = 2'd1,
        WR_DROP = 2'd2
    } wr_state_t;

    // Frame length in words taken from a header word
    function automatic logic [CNT_W:0] hdr_len(input logic [WORD_W-1:0] w);
        return {1'b0, w[CNT_LSB +: CNT_W]} + 1'b1;
    endfunction
endpackage

// File: rtl/rxwf_store.sv
module rxwf_store #(
    parameter int unsigned DEPTH = 256,
    parameter int unsigned DW    = 32,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/rxwf_wr_ctrl.sv
module rxwf_wr_ctrl
    import rxwf_pkg::*;
#(
    parameter int unsigned DEPTH = 256,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic              wr_first,
    input  logic              wr_last,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              release_buf,
    input  logic [AW:0]       fill,
    input  logic [AW-1:0]     wr_base,
    output logic              mem_we,
    output logic [AW-1:0]     mem_waddr,
    output logic              commit,
    output logic [AW:0]       commit_words,
    output logic              drop
);
    wr_state_t      state, nxt;
    logic [AW:0]    stg, rsv;
    logic [CNT_W:0] len;
    logic [AW+1:0]  need;
    logic           fits;

    always_comb begin
        len  = hdr_len(wr_data);
        need = {1'b0, fill} + (AW+2)'(len);
        fits = need <= (AW+2)'(DEPTH);
    end

    // State register and staging counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= WR_IDLE;
            stg   <= '0;
            rsv   <= '0;
        end else begin
            state <= nxt;
            if (state == WR_IDLE && wr_valid && wr_first && fits) begin
                stg <= (AW+1)'(1);
                rsv <= (AW+1)'(len);
            end else if (state == WR_FILL && mem_we) begin
                stg <= stg + 1'b1;
            end
        end
    end

    // Next state and outputs
    always_comb begin
        nxt          = state;
        mem_we       = 1'b0;
        mem_waddr    = wr_base + stg[AW-1:0];
        commit       = 1'b0;
        commit_words = '0;
        drop         = 1'b0;
        unique case (state)
            WR_IDLE: begin
                if (wr_valid && wr_first) begin
                    if (fits) begin
                        mem_we    = 1'b1;
                        mem_waddr = wr_base;
                        if (wr_last) begin
                            commit       = 1'b1;
                            commit_words = (AW+1)'(1);
                        end else begin
                            nxt = WR_FILL;
                        end
                    end else begin
                        drop = 1'b1;
                        if (!wr_last) nxt = WR_DROP;
                    end
                end
            end
            WR_FILL: begin
                if (wr_valid) begin
                    mem_we = stg < rsv;
                    if (wr_last) begin
                        commit       = 1'b1;
                        commit_words = stg + {{AW{1'b0}}, mem_we};
                        nxt          = WR_IDLE;
                    end
                end
            end
            WR_DROP: begin
                if (wr_valid && wr_last) nxt = WR_IDLE;
            end
            default: nxt = WR_IDLE;
        endcase
        if (release_buf) begin
            commit       = 1'b0;
            commit_words = '0;
            if (wr_valid && wr_last)
                nxt = WR_IDLE;
            else if (state == WR_IDLE && !(wr_valid && wr_first))
                nxt = WR_IDLE;
            else
                nxt = WR_DROP;
        end
    end
endmodule

// File: rtl/rxwf_rd_track.sv
module rxwf_rd_track
    import rxwf_pkg::*;
#(
    parameter int unsigned DEPTH = 256,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pop,
    input  logic [WORD_W-1:0] head,
    input  logic              inc,
    input  logic              release_buf,
    output logic [AW:0]       frame_cnt
);
    logic [CNT_W:0] rem, rem_ld, rem_nx;
    logic           dec;

    always_comb begin
        rem_ld = (rem == '0) ? hdr_len(head) : rem;
        rem_nx = rem_ld - 1'b1;
        dec    = pop && (rem_nx == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem       <= '0;
            frame_cnt <= '0;
        end else if (release_buf) begin
            rem       <= '0;
            frame_cnt <= '0;
        end else begin
            if (pop) rem <= rem_nx;
            frame_cnt <= frame_cnt + {{AW{1'b0}}, inc} - {{AW{1'b0}}, dec};
        end
    end
endmodule

// File: rtl/rx_word_fifo.sv
module rx_word_fifo
    import rxwf_pkg::*;
#(
    parameter int unsigned DEPTH = 256,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic              wr_first,
    input  logic              wr_last,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    input  logic              release_buf,
    input  logic              clear_overrun,
    output logic              empty,
    output logic              full,
    output logic [AW:0]       free_words,
    output logic [AW:0]       size_words,
    output logic [AW-1:0]     rd_ptr,
    output logic [AW-1:0]     wr_ptr,
    output logic [AW:0]       frame_count,
    output logic              overrun,
    output logic              ev_frame_in,
    output logic              ev_overrun,
    output logic [31:0]       frames_received
);
    logic [AW:0]       fill;
    logic              pop;
    logic              mem_we, commit, drop;
    logic [AW-1:0]     mem_waddr;
    logic [AW:0]       commit_words;
    logic [WORD_W-1:0] mem_rdata;

    assign pop    = rd_en && (fill != '0) && !release_buf;
    assign wr_ptr = rd_ptr + fill[AW-1:0];

    rxwf_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_first(wr_first), .wr_last(wr_last),
        .wr_data(wr_data), .release_buf(release_buf),
        .fill(fill), .wr_base(wr_ptr),
        .mem_we(mem_we), .mem_waddr(mem_waddr),
        .commit(commit), .commit_words(commit_words), .drop(drop)
    );

    rxwf_store #(.DEPTH(DEPTH), .DW(WORD_W)) u_mem (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(wr_data),
        .raddr(rd_ptr), .rdata(mem_rdata)
    );

    rxwf_rd_track #(.DEPTH(DEPTH)) u_rd (
        .clk(clk), .rst_n(rst_n), .pop(pop), .head(mem_rdata),
        .inc(commit), .release_buf(release_buf), .frame_cnt(frame_count)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill            <= '0;
            rd_ptr          <= '0;
            overrun         <= 1'b0;
            frames_received <= '0;
        end else begin
            if (release_buf) begin
                fill   <= '0;
                rd_ptr <= '0;
            end else begin
                fill <= fill + (commit ? commit_words : '0) - {{AW{1'b0}}, pop};
                if (pop) rd_ptr <= rd_ptr + 1'b1;
            end
            if (drop)               overrun <= 1'b1;
            else if (clear_overrun) overrun <= 1'b0;
            if (commit) frames_received <= frames_received + 1'b1;
        end
    end

    assign rd_data     = (fill != '0) ? mem_rdata : '0;
    assign empty       = frame_count == '0;
    assign full        = fill == (AW+1)'(DEPTH);
    assign free_words  = (AW+1)'(DEPTH) - fill;
    assign size_words  = (AW+1)'(DEPTH);
    assign ev_frame_in = commit;
    assign ev_overrun  = drop;
endmodule

// File: rtl/rx_word_fifo_chk.sv
module rx_word_fifo_chk #(
    parameter int unsigned DEPTH = 256,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_en,
    input logic          release_buf,
    input logic          clear_overrun,
    input logic [31:0]   rd_data,
    input logic [AW:0]   free_words,
    input logic [AW:0]   size_words,
    input logic [AW-1:0] rd_ptr,
    input logic [AW-1:0] wr_ptr,
    input logic [AW:0]   frame_count,
    input logic          overrun,
    input logic          full,
    input logic          ev_frame_in,
    input logic          ev_overrun,
    input logic [31:0]   frames_received
);
    AST_FRAME_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
        ev_frame_in |=> frames_received == $past(frames_received) + 32'd1); // R2
    AST_DROP_KEEPS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_overrun && !release_buf) |=> wr_ptr == $past(wr_ptr)); // R3
    AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_overrun |=> overrun); // R3
    AST_POP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !release_buf && free_words != size_words)
            |=> rd_ptr == $past(rd_ptr) + 1'b1); // R4
    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (free_words == size_words) |-> rd_data == 32'd0); // R6
    AST_EMPTY_READ_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !release_buf && free_words == size_words) |=> $stable(rd_ptr)); // R6
    AST_FULL_NO_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> free_words == '0); // R7
    AST_RELEASE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        release_buf |=> (rd_ptr == '0 && frame_count == '0 && free_words == size_words)); // R9
    AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_overrun && !ev_overrun) |=> !overrun); // R10
endmodule

bind rx_word_fifo rx_word_fifo_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/rx_word_fifo_test.sv
module rx_word_fifo_test;
    localparam int DEPTH = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0, wr_first = 1'b0, wr_last = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0, release_buf = 1'b0, clear_overrun = 1'b0;
    logic [31:0] rd_data, frames_received;
    logic        empty, full, overrun, ev_frame_in, ev_overrun;
    logic [8:0]  free_words, size_words, frame_count;
    logic [7:0]  rd_ptr, wr_ptr;

    rx_word_fifo uut (.*);

    always #2 clk = ~clk;

    int checks = 0, errors = 0;
    int unsigned mq[$];
    int m_rem = 0, m_frames = 0, m_rd = 0, m_total = 0;
    bit m_ovr = 0;

    function automatic int hdr_cnt(input int unsigned w);
        return (w >> 11) & 31;
    endfunction

    function automatic int unsigned make_hdr(input int cnt);
        int unsigned w = $urandom;
        w = (w & ~(32'h1F << 11)) | (32'(cnt) << 11);
        return w;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_status(input string req);
        chk(free_words == 9'(DEPTH - mq.size()), req, "free_words", free_words, DEPTH - mq.size());
        chk(frame_count == 9'(m_frames), req, "frame_count", frame_count, m_frames);
        chk(empty == (m_frames == 0), req, "empty", empty, m_frames == 0);
        chk(rd_ptr == 8'(m_rd), req, "rd_ptr", rd_ptr, m_rd);
        chk(wr_ptr == 8'((m_rd + mq.size()) % DEPTH), "R8", "wr_ptr", wr_ptr, (m_rd + mq.size()) % DEPTH);
        chk(full == (mq.size() == DEPTH), "R7", "full", full, mq.size() == DEPTH);
        chk(overrun == m_ovr, req, "overrun", overrun, m_ovr);
        chk(frames_received == 32'(m_total), req, "frames_received", frames_received, m_total);
    endtask

    task automatic send_frame(input int cnt);
        int unsigned words[$];
        int  len = cnt + 1;
        bit  fits = (mq.size() + len) <= DEPTH;
        words.push_back(make_hdr(cnt));
        for (int i = 1; i < len; i++) words.push_back($urandom);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            wr_valid = 1'b1; wr_first = (i == 0); wr_last = (i == len - 1);
            wr_data = words[i];
            #1;
            if (i == 0) chk(ev_overrun == !fits, "R3", "ev_overrun", ev_overrun, !fits);
            if (i == len - 1) chk(ev_frame_in == fits, "R2", "ev_frame_in", ev_frame_in, fits);
        end
        @(negedge clk);
        wr_valid = 1'b0; wr_first = 1'b0; wr_last = 1'b0;
        if (fits) begin
            foreach (words[i]) mq.push_back(words[i]);
            m_frames++; m_total++;
        end else begin
            m_ovr = 1;
        end
        #1 chk_status(fits ? "R2" : "R3");
    endtask

    task automatic pop_word();
        int unsigned exp;
        @(negedge clk);
        exp = (mq.size() != 0) ? mq[0] : 0;
        chk(rd_data == exp, mq.size() != 0 ? "R4" : "R6", "rd_data", rd_data, exp);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        if (mq.size() != 0) begin
            int unsigned w = mq.pop_front();
            if (m_rem == 0) m_rem = hdr_cnt(w) + 1;
            m_rem--;
            if (m_rem == 0) m_frames--;
            m_rd = (m_rd + 1) % DEPTH;
        end
        #1 chk_status("R5");
    endtask

    task automatic model_release();
        mq.delete(); m_rem = 0; m_frames = 0; m_rd = 0;
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5eed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(size_words == 9'd256, "R1", "size_words", size_words, 256);
        chk_status("R1");
        // R6 read while empty
        pop_word();
        // Random mix of frames and pop bursts
        for (int op = 0; op < 400; op++) begin
            if ($urandom_range(0, 2) != 0) send_frame($urandom_range(3, 20));
            else repeat ($urandom_range(1, 12)) pop_word();
        end
        while (mq.size() != 0) pop_word();
        // R9 release from a mid-position pointer
        @(negedge clk); release_buf = 1'b1;
        @(negedge clk); release_buf = 1'b0; model_release();
        #1 chk_status("R9");
        // R7 exact fill with maximum-length frames
        repeat (8) send_frame(31);
        chk(full == 1'b1, "R7", "full at capacity", full, 1);
        // R3 overrun at capacity
        send_frame(3);
        // R10 clear overrun
        @(negedge clk); clear_overrun = 1'b1;
        @(negedge clk); clear_overrun = 1'b0; m_ovr = 0;
        #1 chk(overrun == 1'b0, "R10", "overrun after clear", overrun, 0);
        // R5 partial read keeps frame counted
        repeat (5) pop_word();
        chk(frame_count == 9'd8, "R5", "frame_count partial", frame_count, 8);
        chk(empty == 1'b0, "R5", "empty partial", empty, 0);
        // R3 frame that would just fit after 5 pops: 5 words fits, 6 does not
        send_frame(5);
        send_frame(4);
        // R9 release while a frame is in flight
        @(negedge clk); release_buf = 1'b1;
        @(negedge clk); release_buf = 1'b0; model_release();
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            wr_valid = 1'b1; wr_first = (i == 0); wr_last = 1'b0;
            wr_data = (i == 0) ? make_hdr(5) : $urandom;
            release_buf = (i == 2);
            if (i == 5) wr_last = 1'b1;
        end
        @(negedge clk);
        wr_valid = 1'b0; wr_first = 1'b0; wr_last = 1'b0; release_buf = 1'b0;
        #1 chk_status("R9");
        // R4/R5 normal frame after release, read back whole
        send_frame(6);
        repeat (8) pop_word();
        chk(empty == 1'b1, "R5", "empty after drain", empty, 1);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule